// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Controller

This block sits beside the high-side switch driver of a buck regulator and decides, on every clock, whether the upper switch may conduct. A strobe marks the start of each switching cycle. A comparator flag reports overcurrent. When the flag rises, the gate enable is cut in the same cycle. The switch then stays off until the next switching cycle begins.

The block counts switching cycles that carry an overcurrent, but only while they come back to back. A cycle with no overcurrent sets the count back to zero. When the run reaches the limit (17 by default), the controller enters a shutdown state. It holds the switch off and counts the soft-start periods that an external ramp generator reports through a done strobe. After eight of them it clears its counters, drops the fault flag and asks for a new soft-start with a one-clock pulse. If the overcurrent has gone by then, regulation resumes at the next switching cycle.

All pins are plain control and status lines. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: Whenever `oc_flag_i` is high, `hs_en_o` is low in that same clock, through a combinational path.
- R2: After `oc_flag_i` has cut the enable, `hs_en_o` stays low for the rest of the switching cycle. It goes high again only from the clock edge that samples `cyc_start_i` high with `oc_flag_i` low.
- R3: The first overcurrent seen in a switching cycle loads the fault count with 1 when the previous cycle was clean. It adds one when the previous cycle was also faulted. Further overcurrent clocks inside the same cycle add nothing. An overcurrent on the strobe clock itself belongs to the new cycle.
- R4: A switching cycle that ends without any overcurrent clears the consecutive fault count to zero.
- R5: The detection that completes `FAULT_LIMIT` (17) consecutive faulted cycles raises `fault_o` at the next clock edge.
- R6: While `fault_o` is high, `hs_en_o` stays low and `fault_o` stays high. `cyc_start_i` and `oc_flag_i` have no effect in this state.
- R7: In shutdown, `wait_cnt_o` counts the `ss_done_i` strobes received, as an unsigned 4-bit value starting at 0. Outside shutdown it reads 0.
- R8: The edge that samples strobe number `WAIT_PERIODS` (8) ends shutdown. On that edge `fault_o` falls, `ss_restart_o` is high for exactly one clock, `wait_cnt_o` returns to 0 and the fault count is cleared. A full `FAULT_LIMIT` run is then needed to shut down again.
- R9: After the retry, `hs_en_o` stays low until the next switching-cycle strobe. From that strobe it is high if no overcurrent is present.
- R10: `ss_done_i` outside shutdown has no effect on `wait_cnt_o`, `fault_o` or `ss_restart_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start_i | input | 1 | One-clock strobe at the start of each switching cycle |
| oc_flag_i | input | 1 | Overcurrent comparator output, high while the current is over the limit |
| ss_done_i | input | 1 | One-clock strobe at the end of each soft-start period |
| hs_en_o | output | 1 | High-side switch gate enable |
| fault_o | output | 1 | High while in overcurrent shutdown |
| ss_restart_o | output | 1 | One-clock request to start a new soft-start |
| wait_cnt_o | output | 4 | Soft-start periods counted during shutdown |

## Verification
A fault count that has drifted does not show at the ports right away. It shows as a shutdown that comes one or more cycles too early or too late, so the bench sweeps run lengths from 1 to 18 faulted cycles. It also breaks runs with a clean cycle to expose a count that is not cleared. A wrong state bit appears within one clock as a gate enable during shutdown or a fault flag that stays high. A miscounting wait timer moves the restart pulse off the eighth strobe, and the bench checks for that after each strobe.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SHUT = 1'b1
  } hic_state_e;

endpackage

// File: rtl/ocp_cycle_gate.sv
// Per-cycle gating of the high-side switch and first-detection tracking.
module ocp_cycle_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic cyc_start_i,
  input  logic oc_flag_i,
  output logic hs_en_o,
  output logic first_oc_o,
  output logic cycle_clean_o
);

  logic gate_q;
  logic seen_q;

  // first overcurrent of the current cycle; on a strobe clock the old seen bit is stale
  assign first_oc_o    = run_i && oc_flag_i && (cyc_start_i || !seen_q);
  assign cycle_clean_o = run_i && cyc_start_i && !seen_q;
  assign hs_en_o       = run_i && gate_q && !oc_flag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (!run_i) begin
      gate_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (oc_flag_i)        gate_q <= 1'b0;
      else if (cyc_start_i) gate_q <= 1'b1;

      if (cyc_start_i)    seen_q <= oc_flag_i;
      else if (oc_flag_i) seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ocp_fault_counter.sv
// Consecutive faulted-cycle counter.
module ocp_fault_counter #(
  parameter int FAULT_LIMIT = 17,
  localparam int CNT_W = $clog2(FAULT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_oc_i,
  input  logic             cycle_clean_i,
  input  logic             clear_i,
  output logic             limit_hit_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;

  always_comb base = cycle_clean_i ? '0 : cnt_q;

  assign limit_hit_o = first_oc_i && (base == CNT_W'(FAULT_LIMIT - 1));
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (first_oc_i) cnt_q <= base + 1'b1;
    else                 cnt_q <= base;
  end

endmodule

// File: rtl/ocp_hiccup_timer.sv
// Shutdown state and soft-start period wait.
module ocp_hiccup_timer
  import ocp_hiccup_pkg::*;
#(
  parameter int WAIT_PERIODS = 8,
  parameter int PER_W        = 4,
  localparam int WAIT_W      = (WAIT_PERIODS > 1) ? $clog2(WAIT_PERIODS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             limit_hit_i,
  input  logic             ss_done_i,
  output logic             run_o,
  output logic             fault_o,
  output logic             clear_o,
  output logic             restart_o,
  output logic [PER_W-1:0] wait_cnt_o
);

  hic_state_e        state_q;
  logic [WAIT_W-1:0] wait_q;
  logic              restart_q;
  logic              last;

  assign last       = (state_q == ST_SHUT) && ss_done_i &&
                      (wait_q == WAIT_W'(WAIT_PERIODS - 1));
  assign run_o      = (state_q == ST_RUN);
  assign fault_o    = (state_q == ST_SHUT);
  assign clear_o    = last;
  assign restart_o  = restart_q;
  assign wait_cnt_o = PER_W'(wait_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      wait_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= last;
      unique case (state_q)
        ST_RUN: begin
          wait_q <= '0;
          if (limit_hit_i) state_q <= ST_SHUT;
        end
        ST_SHUT: begin
          if (last) begin
            state_q <= ST_RUN;
            wait_q  <= '0;
          end else if (ss_done_i) begin
            wait_q <= wait_q + 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int FAULT_LIMIT  = 17,
  parameter int WAIT_PERIODS = 8,
  parameter int PER_W        = 4,
  localparam int CNT_W       = $clog2(FAULT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start_i,
  input  logic             oc_flag_i,
  input  logic             ss_done_i,
  output logic             hs_en_o,
  output logic             fault_o,
  output logic             ss_restart_o,
  output logic [PER_W-1:0] wait_cnt_o
);

  logic             run;
  logic             first_oc;
  logic             cycle_clean;
  logic             limit_hit;
  logic             clear_cnt;
  logic [CNT_W-1:0] fault_cnt;

  ocp_cycle_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .cyc_start_i   (cyc_start_i),
    .oc_flag_i     (oc_flag_i),
    .hs_en_o       (hs_en_o),
    .first_oc_o    (first_oc),
    .cycle_clean_o (cycle_clean)
  );

  ocp_fault_counter #(.FAULT_LIMIT(FAULT_LIMIT)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .first_oc_i    (first_oc),
    .cycle_clean_i (cycle_clean),
    .clear_i       (clear_cnt),
    .limit_hit_o   (limit_hit),
    .cnt_o         (fault_cnt)
  );

  ocp_hiccup_timer #(.WAIT_PERIODS(WAIT_PERIODS), .PER_W(PER_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .limit_hit_i (limit_hit),
    .ss_done_i   (ss_done_i),
    .run_o       (run),
    .fault_o     (fault_o),
    .clear_o     (clear_cnt),
    .restart_o   (ss_restart_o),
    .wait_cnt_o  (wait_cnt_o)
  );

endmodule

// File: rtl/ocp_hiccup_ctrl_chk.sv
module ocp_hiccup_ctrl_chk #(
  parameter int FAULT_LIMIT  = 17,
  parameter int WAIT_PERIODS = 8,
  parameter int PER_W        = 4,
  parameter int CNT_W        = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start_i,
  input logic             oc_flag_i,
  input logic             ss_done_i,
  input logic             hs_en_o,
  input logic             fault_o,
  input logic             ss_restart_o,
  input logic [PER_W-1:0] wait_cnt_o,
  input logic [CNT_W-1:0] fault_cnt
);

  a_r1_oc_cuts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag_i |-> !hs_en_o);

  a_r2_gate_rises_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> $past(cyc_start_i) && $past(!oc_flag_i));

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cnt <= CNT_W'(FAULT_LIMIT));

  a_r5_shut_after_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(oc_flag_i) && ($past(fault_cnt) == CNT_W'(FAULT_LIMIT - 1)));

  a_r6_no_gate_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !hs_en_o);

  a_r7_wait_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> (wait_cnt_o == '0));

  a_r8_retry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart_o |-> !fault_o && $past(fault_o) && $past(ss_done_i) && (fault_cnt == '0));

  a_r8_retry_single: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart_o |=> !ss_restart_o);

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_ctrl_chk #(
  .FAULT_LIMIT  (FAULT_LIMIT),
  .WAIT_PERIODS (WAIT_PERIODS),
  .PER_W        (PER_W),
  .CNT_W        (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cyc_start_i  (cyc_start_i),
  .oc_flag_i    (oc_flag_i),
  .ss_done_i    (ss_done_i),
  .hs_en_o      (hs_en_o),
  .fault_o      (fault_o),
  .ss_restart_o (ss_restart_o),
  .wait_cnt_o   (wait_cnt_o),
  .fault_cnt    (fault_cnt)
);

// File: tb/ocp_hiccup_ctrl_tb.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl_tb;

  localparam int LIMIT = 17;
  localparam int WAITN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic       oc = 1'b0;
  logic       ss_done = 1'b0;
  logic       hs_en;
  logic       fault;
  logic       restart;
  logic [3:0] wait_cnt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ocp_hiccup_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_start_i  (cyc_start),
    .oc_flag_i    (oc),
    .ss_done_i    (ss_done),
    .hs_en_o      (hs_en),
    .fault_o      (fault),
    .ss_restart_o (restart),
    .wait_cnt_o   (wait_cnt)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cyc_start = 1'b0; oc = 1'b0; ss_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one 4-clock switching cycle; mask bit k drives overcurrent on clock k
  task automatic sw_cycle(input logic [3:0] mask);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cyc_start = (k == 0);
      oc = mask[k];
      #1;
      if (mask[k]) chk(hs_en, 0, "R1 oc cuts enable");
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_start = 1'b0; oc = 1'b0; ss_done = 1'b0;
    end
    #1;
  endtask

  // deliver WAITN strobes and check the count and the retry pulse
  task automatic hiccup_wait();
    for (int i = 1; i <= WAITN; i++) begin
      @(negedge clk); ss_done = 1'b1; cyc_start = 1'b0; oc = 1'b0;
      @(negedge clk); ss_done = 1'b0; #1;
      if (i < WAITN) begin
        chk(wait_cnt, i, "R7 wait count");
        chk(fault, 1, "R6 fault held");
      end else begin
        chk(fault, 0, "R8 fault drops");
        chk(restart, 1, "R8 restart pulse");
        chk(wait_cnt, 0, "R8 wait cleared");
      end
    end
    @(negedge clk); #1;
    chk(restart, 0, "R8 restart one clock");
  endtask

  initial begin
    do_reset();
    #1;
    chk(hs_en, 0, "R2 reset enable");
    chk(fault, 0, "R5 reset fault");
    chk(restart, 0, "R8 reset restart");
    chk(wait_cnt, 0, "R7 reset wait");

    // R2: clean cycle enables from the strobe edge
    sw_cycle(4'b0000);
    chk(hs_en, 1, "R2 enable after strobe");
    // R1/R2: cut mid-cycle and stay low after flag falls
    @(negedge clk); cyc_start = 1'b1; oc = 1'b0; #1;
    chk(hs_en, 1, "R2 enable before new strobe edge");
    @(negedge clk); cyc_start = 1'b0; oc = 1'b1; #1;
    chk(hs_en, 0, "R1 cut same clock");
    @(negedge clk); oc = 1'b0; #1;
    chk(hs_en, 0, "R2 stays low in cycle");
    @(negedge clk); #1;
    chk(hs_en, 0, "R2 stays low until strobe");
    sw_cycle(4'b0000);
    chk(hs_en, 1, "R2 back after strobe");

    // R3/R5: sweep run lengths and overcurrent positions
    for (int n = 1; n <= LIMIT + 1; n++) begin
      do_reset();
      for (int c = 0; c < n && c < LIMIT; c++) sw_cycle(4'b0001 << ((c + n) % 4));
      idle(1);
      chk(fault, (n >= LIMIT) ? 1 : 0, $sformatf("R3 run length %0d", n));
      chk(hs_en, 0, "R1 enable low after faults");
    end

    // R3: many overcurrent clocks per cycle count once
    do_reset();
    for (int c = 0; c < LIMIT - 1; c++) sw_cycle(4'b1111);
    idle(1);
    chk(fault, 0, "R3 multi-pulse cycle counts once");

    // R4: clean cycle restarts the run
    do_reset();
    for (int c = 0; c < LIMIT - 1; c++) sw_cycle(4'b0010);
    sw_cycle(4'b0000);
    for (int c = 0; c < LIMIT - 1; c++) sw_cycle(4'b0100);
    idle(1);
    chk(fault, 0, "R4 clean cycle clears count");

    // R5: exact edge of shutdown
    do_reset();
    for (int c = 0; c < LIMIT - 1; c++) sw_cycle(4'b0010);
    @(negedge clk); cyc_start = 1'b1; oc = 1'b0;
    @(negedge clk); cyc_start = 1'b0; oc = 1'b1; #1;
    chk(fault, 0, "R5 fault not before edge");
    @(negedge clk); oc = 1'b0; #1;
    chk(fault, 1, "R5 fault after 17th detection");
    chk(wait_cnt, 0, "R7 wait starts at zero");

    // R6: strobes and overcurrent ignored in shutdown
    @(negedge clk); cyc_start = 1'b1; oc = 1'b0; #1;
    chk(hs_en, 0, "R6 no enable on strobe");
    @(negedge clk); cyc_start = 1'b0; #1;
    chk(hs_en, 0, "R6 no enable after strobe");
    chk(fault, 1, "R6 fault held");
    @(negedge clk); oc = 1'b1; cyc_start = 1'b1;
    @(negedge clk); oc = 1'b0; cyc_start = 1'b0; #1;
    chk(fault, 1, "R6 fault held under oc");
    chk(wait_cnt, 0, "R6 oc does not move wait");

    // R7/R8: hiccup wait and retry
    hiccup_wait();
    chk(hs_en, 0, "R9 no enable before strobe");
    sw_cycle(4'b0000);
    chk(hs_en, 1, "R9 enable after retry strobe");

    // R8: counters cleared, needs a full run again
    for (int c = 0; c < LIMIT - 1; c++) sw_cycle(4'b0001);
    idle(1);
    chk(fault, 0, "R8 count cleared at retry");
    sw_cycle(4'b0001);
    idle(1);
    chk(fault, 1, "R8 full run shuts down again");
    hiccup_wait();

    // R10: soft-start strobes ignored while running
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ss_done = 1'b1;
    end
    @(negedge clk); ss_done = 1'b0; #1;
    chk(wait_cnt, 0, "R10 wait unchanged");
    chk(fault, 0, "R10 fault unchanged");
    chk(restart, 0, "R10 no restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule